// File: doc/BRIEF.md
# Programmable Color Space Converter

A three-stage pipelined 3x3 matrix unit for 8-bit, three-component pixels. It handles RGB to YCbCr, YCbCr to RGB and RGB pass-through. Each output channel is a signed weighted sum of the three input channels, plus a per-channel offset. The sum is scaled by a power of two, rounded to nearest and clamped. The clamp is either to full range or to video range.

The parameter set comes from one of two places. Software can load six 32-bit words through a small write port. Alternatively, one of three fixed preset sets can be picked on `preset_i`. Neither source changes the conversion at once. A staged set becomes active only on the clock edge where `frame_start_i` is high, so a frame is never converted with two different parameter sets.

Pixels enter and leave on a valid/ready stream. A single stall signal freezes the whole pipeline whenever the output is held.

Top module: `csc_top`

## Requirements
- R1: While `rst_ni` is low, `out_valid_o` is 0. After reset, with the pipeline empty, `in_ready_o` is 1.
- R2: Coefficients are 9-bit two's complement values c[i][j], where output channel i weights input channel j. Word 0 holds c[0][0] in [26:18], c[1][1] in [17:9] and c[2][2] in [8:0]. Word 2 holds c[0][1], c[1][0] and c[2][0] in the same three fields. Word 4 holds c[0][2], c[1][2] and c[2][1] in those fields.
- R3: Each channel offset is a 13-bit two's complement value with 2 fractional bits. The low 5 bits sit in [31:27] of word 0, 2 or 4, for channels 0, 1 and 2. The high 8 bits sit in [7:0] of word 1, 3 or 5, for the same channels.
- R4: Each output is floor((S·2^k + 256) / 512), where S = Σ c[i][j]·x_j + 64·offset[i] and k is the scale. This is rounding to nearest with halves going up. Without saturation the result is clamped to 0..255.
- R5: The scale k is word 1 [9:8] and takes any value 0..3. Channel 0 is pixel bits [23:16], channel 1 is [15:8] and channel 2 is [7:0], on both the input and the output.
- R6: The saturate flag is word 1 [10]. When it is set, channel 0 clamps to 16..235 and channels 1 and 2 clamp to 16..240.
- R7: `preset_i` selects the set to stage:
  - 0: the six programmed words.
  - 1: RGB to YCbCr, with rows {77,150,29}, {-43,-85,128}, {128,-107,-21}, offsets {0,512,512} and scale 1.
  - 2: YCbCr to RGB, with rows {149,0,204}, {149,-50,-104}, {149,255,0}, offsets {-446,266,-554} and scale 2.
  - 3: pass-through, with a diagonal of 128, zero offsets and scale 2.
  
  None of the presets saturates.
- R8: A set becomes active only on an edge with `frame_start_i` high. A pixel accepted on that same edge still uses the previous set. Word writes and `preset_i` changes without a frame start do not alter any output.
- R9: A pixel accepted on edge k sets `out_valid_o` after edge k+2, provided `in_ready_o` stays high on edges k+1 and k+2. Every accepted pixel leaves once, in order.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `in_ready_o` is 0, and `out_pix_o` and `out_valid_o` hold their values.
- R11: After reset, the active set is pass-through, so pixels leave unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Parameter word write strobe |
| cfg_addr_i | input | 3 | Parameter word index, 0..5 (higher indices ignored) |
| cfg_wdata_i | input | 32 | Parameter word data |
| preset_i | input | 2 | Source of the set staged for the next frame start |
| frame_start_i | input | 1 | Frame boundary; activates the staged set |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted when high together with valid |
| in_pix_i | input | 24 | Input pixel, channel 0 in [23:16] |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream ready |
| out_pix_o | output | 24 | Output pixel, channel 0 in [23:16] |

## Verification
A pixel accepted on an edge shows up on the output after the second edge that follows, as long as no stall intervenes. A new parameter set applies to pixels accepted on the edge after the frame start, never to the pixel accepted on the frame start edge itself.

The bench pushes an expected value for each pixel, computed from the model's active set at the moment of acceptance. It applies frame starts and word writes to the model in the same order the hardware applies them at that edge. Every sample is taken one time unit before the rising edge, so a compare always sees values that have settled.

A dedicated single-pixel probe counts edges to confirm the two-edge offset. During stalls, the held output is compared with its value from the previous cycle.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int PIX_W    = 8;
  localparam int NCH      = 3;
  localparam int COEF_W   = 9;
  localparam int OFF_W    = 13;
  localparam int OFF_LO_W = 5;
  localparam int OFF_HI_W = OFF_W - OFF_LO_W;
  localparam int SCL_W    = 2;
  localparam int WORD_W   = 32;
  localparam int NWORDS   = 6;
  localparam int OFF_SH   = 6;
  localparam int PROD_W   = COEF_W + PIX_W + 1;
  localparam int ACC_W    = PROD_W + 3;
  localparam int BASE_SH  = PIX_W + 1;
  localparam int SAT_LO   = 16;
  localparam int SAT_Y_HI = 235;
  localparam int SAT_C_HI = 240;
  localparam int FULL_HI  = (1 << PIX_W) - 1;

  typedef enum logic [1:0] {
    PS_PROG    = 2'd0,
    PS_RGB2YCC = 2'd1,
    PS_YCC2RGB = 2'd2,
    PS_PASS    = 2'd3
  } preset_e;

  typedef struct packed {
    logic [NCH-1:0][NCH-1:0][COEF_W-1:0] coef;
    logic [NCH-1:0][OFF_W-1:0]           off;
    logic [SCL_W-1:0]                    scale;
    logic                                sat;
  } csc_par_t;

  function automatic csc_par_t preset_par(input preset_e sel);
    csc_par_t p;
    p = '0;
    case (sel)
      PS_RGB2YCC: begin
        p.coef[0][0] = 9'd77;  p.coef[0][1] = 9'd150; p.coef[0][2] = 9'd29;
        p.coef[1][0] = 9'd469; p.coef[1][1] = 9'd427; p.coef[1][2] = 9'd128;
        p.coef[2][0] = 9'd128; p.coef[2][1] = 9'd405; p.coef[2][2] = 9'd491;
        p.off[1] = 13'd512;
        p.off[2] = 13'd512;
        p.scale  = 2'd1;
      end
      PS_YCC2RGB: begin
        p.coef[0][0] = 9'd149; p.coef[0][1] = 9'd0;   p.coef[0][2] = 9'd204;
        p.coef[1][0] = 9'd149; p.coef[1][1] = 9'd462; p.coef[1][2] = 9'd408;
        p.coef[2][0] = 9'd149; p.coef[2][1] = 9'd255; p.coef[2][2] = 9'd0;
        p.off[0] = 13'h1E42;
        p.off[1] = 13'h010A;
        p.off[2] = 13'h1DD6;
        p.scale  = 2'd2;
      end
      default: begin
        for (int i = 0; i < NCH; i++) p.coef[i][i] = 9'd128;
        p.scale = 2'd2;
      end
    endcase
    return p;
  endfunction

  // field positions are fixed by the software-visible word layout
  function automatic csc_par_t unpack_words(input logic [NWORDS-1:0][WORD_W-1:0] w);
    csc_par_t p;
    p = '0;
    p.coef[0][0] = w[0][26:18]; p.coef[1][1] = w[0][17:9]; p.coef[2][2] = w[0][8:0];
    p.coef[0][1] = w[2][26:18]; p.coef[1][0] = w[2][17:9]; p.coef[2][0] = w[2][8:0];
    p.coef[0][2] = w[4][26:18]; p.coef[1][2] = w[4][17:9]; p.coef[2][1] = w[4][8:0];
    for (int i = 0; i < NCH; i++)
      p.off[i] = {w[2*i+1][OFF_HI_W-1:0], w[2*i][WORD_W-1 -: OFF_LO_W]};
    p.scale = w[1][9:8];
    p.sat   = w[1][10];
    return p;
  endfunction
endpackage

// File: rtl/csc_cfg.sv
module csc_cfg
  import csc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [1:0]        preset_i,
  input  logic              commit_i,
  output csc_par_t          par_o
);
  logic [NWORDS-1:0][WORD_W-1:0] shw_q;
  csc_par_t                      act_q;
  csc_par_t                      staged;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shw_q <= '0;
    end else if (we_i) begin
      for (int w = 0; w < NWORDS; w++)
        if (addr_i == ADDR_W'(w)) shw_q[w] <= wdata_i;
    end
  end

  always_comb begin
    if (preset_e'(preset_i) == PS_PROG) staged = unpack_words(shw_q);
    else                                staged = preset_par(preset_e'(preset_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       act_q <= preset_par(PS_PASS);
    else if (commit_i) act_q <= staged;
  end

  assign par_o = act_q;
endmodule

// File: rtl/csc_mult.sv
module csc_mult
  import csc_pkg::*;
(
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                en_i,
  input  logic                                vld_i,
  input  logic [NCH*PIX_W-1:0]                pix_i,
  input  csc_par_t                            par_i,
  output logic                                vld_o,
  output logic [NCH-1:0][NCH-1:0][PROD_W-1:0] prod_o,
  output logic [NCH-1:0][OFF_W-1:0]           off_o,
  output logic [SCL_W-1:0]                    scale_o,
  output logic                                sat_o
);
  logic                        vld_q;
  logic [NCH-1:0][OFF_W-1:0]   off_q;
  logic [SCL_W-1:0]            scale_q;
  logic                        sat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   vld_q <= 1'b0;
    else if (en_i) vld_q <= vld_i;
  end

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      off_q   <= par_i.off;
      scale_q <= par_i.scale;
      sat_q   <= par_i.sat;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_row
    for (genvar j = 0; j < NCH; j++) begin : g_col
      logic signed [PROD_W-1:0] prd_q;
      logic signed [PIX_W:0]    xs;
      assign xs = {1'b0, pix_i[(NCH-1-j)*PIX_W +: PIX_W]};
      always_ff @(posedge clk_i) begin
        if (en_i) prd_q <= $signed(par_i.coef[i][j]) * xs;
      end
      assign prod_o[i][j] = prd_q;
    end
  end

  assign vld_o   = vld_q;
  assign off_o   = off_q;
  assign scale_o = scale_q;
  assign sat_o   = sat_q;
endmodule

// File: rtl/csc_sum.sv
module csc_sum
  import csc_pkg::*;
(
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                en_i,
  input  logic                                vld_i,
  input  logic [NCH-1:0][NCH-1:0][PROD_W-1:0] prod_i,
  input  logic [NCH-1:0][OFF_W-1:0]           off_i,
  input  logic [SCL_W-1:0]                    scale_i,
  input  logic                                sat_i,
  output logic                                vld_o,
  output logic [NCH-1:0][ACC_W-1:0]           acc_o,
  output logic [SCL_W-1:0]                    scale_o,
  output logic                                sat_o
);
  logic             vld_q;
  logic [SCL_W-1:0] scale_q;
  logic             sat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   vld_q <= 1'b0;
    else if (en_i) vld_q <= vld_i;
  end

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      scale_q <= scale_i;
      sat_q   <= sat_i;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic signed [ACC_W-1:0] sum_d;
    logic signed [ACC_W-1:0] acc_q;
    always_comb begin
      sum_d = ACC_W'($signed(off_i[i])) <<< OFF_SH;
      for (int j = 0; j < NCH; j++)
        sum_d = sum_d + ACC_W'($signed(prod_i[i][j]));
    end
    always_ff @(posedge clk_i) begin
      if (en_i) acc_q <= sum_d;
    end
    assign acc_o[i] = acc_q;
  end

  assign vld_o   = vld_q;
  assign scale_o = scale_q;
  assign sat_o   = sat_q;
endmodule

// File: rtl/csc_out.sv
module csc_out
  import csc_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic                      vld_i,
  input  logic [NCH-1:0][ACC_W-1:0] acc_i,
  input  logic [SCL_W-1:0]          scale_i,
  input  logic                      sat_i,
  output logic                      vld_o,
  output logic [NCH*PIX_W-1:0]      pix_o,
  output logic                      sat_o
);
  logic vld_q;
  logic sat_q;
  logic [3:0] sh;

  always_comb sh = 4'(BASE_SH) - {2'b00, scale_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   vld_q <= 1'b0;
    else if (en_i) vld_q <= vld_i;
  end

  always_ff @(posedge clk_i) begin
    if (en_i) sat_q <= sat_i;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic signed [ACC_W:0] HI_SAT = (i == 0) ? ACC_W'(SAT_Y_HI) : ACC_W'(SAT_C_HI);
    localparam logic signed [ACC_W:0] LO_SAT = (ACC_W+1)'(SAT_LO);
    localparam logic signed [ACC_W:0] HI_RAW = (ACC_W+1)'(FULL_HI);
    logic signed [ACC_W:0] rnd, tmp, res, lo, hi;
    logic [PIX_W-1:0]      y_d, y_q;

    always_comb begin
      rnd = (ACC_W+1)'(1) << (sh - 4'd1);
      tmp = $signed({acc_i[i][ACC_W-1], acc_i[i]}) + rnd;
      res = tmp >>> sh;
      lo  = sat_i ? LO_SAT : '0;
      hi  = sat_i ? HI_SAT : HI_RAW;
      if (res < lo)      y_d = lo[PIX_W-1:0];
      else if (res > hi) y_d = hi[PIX_W-1:0];
      else               y_d = res[PIX_W-1:0];
    end

    always_ff @(posedge clk_i) begin
      if (en_i) y_q <= y_d;
    end
    assign pix_o[(NCH-1-i)*PIX_W +: PIX_W] = y_q;
  end

  assign vld_o = vld_q;
  assign sat_o = sat_q;
endmodule

// File: rtl/csc_top.sv
module csc_top
  import csc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [ADDR_W-1:0]    cfg_addr_i,
  input  logic [WORD_W-1:0]    cfg_wdata_i,
  input  logic [1:0]           preset_i,
  input  logic                 frame_start_i,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [NCH*PIX_W-1:0] in_pix_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [NCH*PIX_W-1:0] out_pix_o
);
  csc_par_t                            act;
  logic                                adv;
  logic                                v1, v2, o_sat;
  logic [NCH-1:0][NCH-1:0][PROD_W-1:0] prod;
  logic [NCH-1:0][OFF_W-1:0]           off1;
  logic [SCL_W-1:0]                    scl1, scl2;
  logic                                sat1, sat2;
  logic [NCH-1:0][ACC_W-1:0]           acc;

  // one enable for all stages: a held output freezes the whole pipe
  assign adv        = !out_valid_o || out_ready_i;
  assign in_ready_o = adv;

  csc_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .preset_i (preset_i),
    .commit_i (frame_start_i),
    .par_o    (act)
  );

  csc_mult u_mult (
    .clk_i, .rst_ni,
    .en_i    (adv),
    .vld_i   (in_valid_i),
    .pix_i   (in_pix_i),
    .par_i   (act),
    .vld_o   (v1),
    .prod_o  (prod),
    .off_o   (off1),
    .scale_o (scl1),
    .sat_o   (sat1)
  );

  csc_sum u_sum (
    .clk_i, .rst_ni,
    .en_i    (adv),
    .vld_i   (v1),
    .prod_i  (prod),
    .off_i   (off1),
    .scale_i (scl1),
    .sat_i   (sat1),
    .vld_o   (v2),
    .acc_o   (acc),
    .scale_o (scl2),
    .sat_o   (sat2)
  );

  csc_out u_out (
    .clk_i, .rst_ni,
    .en_i    (adv),
    .vld_i   (v2),
    .acc_i   (acc),
    .scale_i (scl2),
    .sat_i   (sat2),
    .vld_o   (out_valid_o),
    .pix_o   (out_pix_o),
    .sat_o   (o_sat)
  );
endmodule

// File: rtl/csc_chk.sv
module csc_chk
  import csc_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 in_valid_i,
  input logic                 in_ready_o,
  input logic                 out_valid_o,
  input logic                 out_ready_i,
  input logic [NCH*PIX_W-1:0] out_pix_o,
  input logic                 frame_start_i,
  input csc_par_t             act_par,
  input logic                 out_sat
);
  a_r1_idle_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> !out_valid_o);

  a_r9_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o ##1 in_ready_o ##1 in_ready_o |=> out_valid_o);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_pix_o));

  a_r8_commit_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(act_par));

  a_r6_sat_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_sat |->
      out_pix_o[23:16] >= 8'(SAT_LO) && out_pix_o[23:16] <= 8'(SAT_Y_HI) &&
      out_pix_o[15:8]  >= 8'(SAT_LO) && out_pix_o[15:8]  <= 8'(SAT_C_HI) &&
      out_pix_o[7:0]   >= 8'(SAT_LO) && out_pix_o[7:0]   <= 8'(SAT_C_HI));

  a_r4_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !$isunknown(out_pix_o));
endmodule

bind csc_top csc_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .in_ready_o    (in_ready_o),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .out_pix_o     (out_pix_o),
  .frame_start_i (frame_start_i),
  .act_par       (act),
  .out_sat       (o_sat)
);

// File: tb/sim_csc_top.sv
module sim_csc_top;
  localparam int PER  = 10;
  localparam int HALF = PER / 2;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        cfg_we_i;
  logic [2:0]  cfg_addr_i;
  logic [31:0] cfg_wdata_i;
  logic [1:0]  preset_i;
  logic        frame_start_i;
  logic        in_valid_i;
  logic        in_ready_o;
  logic [23:0] in_pix_i;
  logic        out_valid_o;
  logic        out_ready_i;
  logic [23:0] out_pix_o;

  always #(HALF) clk = ~clk;

  csc_top u0 (
    .clk_i(clk), .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .preset_i,
    .frame_start_i, .in_valid_i, .in_ready_o, .in_pix_i, .out_valid_o,
    .out_ready_i, .out_pix_o
  );

  int n_run = 0;
  int n_fail = 0;
  string tag = "R1";
  bit done = 0;

  int mc[3][3];
  int mo[3];
  int msc;
  int msat;
  logic [31:0] sw[6];
  int pc[3][3];
  int po[3];
  logic [23:0] expq[$];
  bit mon_acc = 0;
  bit prev_stall = 0;
  logic [23:0] prev_pix;

  task automatic chk(input bit ok, input string req, input logic [23:0] a, input logic [23:0] e);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, a, e, $time);
    end
  endtask

  function automatic int sx(input int v, input int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  function automatic int fdiv(input int a, input int b);
    int q;
    q = a / b;
    if ((a % b != 0) && (a < 0)) q = q - 1;
    return q;
  endfunction

  task automatic load_preset(input int sel);
    for (int i = 0; i < 3; i++) begin
      mo[i] = 0;
      for (int j = 0; j < 3; j++) mc[i][j] = 0;
    end
    msat = 0;
    case (sel)
      1: begin
        mc[0][0] = 77;  mc[0][1] = 150; mc[0][2] = 29;
        mc[1][0] = -43; mc[1][1] = -85; mc[1][2] = 128;
        mc[2][0] = 128; mc[2][1] = -107; mc[2][2] = -21;
        mo[1] = 512; mo[2] = 512; msc = 1;
      end
      2: begin
        mc[0][0] = 149; mc[0][1] = 0;   mc[0][2] = 204;
        mc[1][0] = 149; mc[1][1] = -50; mc[1][2] = -104;
        mc[2][0] = 149; mc[2][1] = 255; mc[2][2] = 0;
        mo[0] = -446; mo[1] = 266; mo[2] = -554; msc = 2;
      end
      default: begin
        mc[0][0] = 128; mc[1][1] = 128; mc[2][2] = 128; msc = 2;
      end
    endcase
  endtask

  task automatic decode_shadow();
    mc[0][0] = sx(int'(sw[0][26:18]), 9); mc[1][1] = sx(int'(sw[0][17:9]), 9); mc[2][2] = sx(int'(sw[0][8:0]), 9);
    mc[0][1] = sx(int'(sw[2][26:18]), 9); mc[1][0] = sx(int'(sw[2][17:9]), 9); mc[2][0] = sx(int'(sw[2][8:0]), 9);
    mc[0][2] = sx(int'(sw[4][26:18]), 9); mc[1][2] = sx(int'(sw[4][17:9]), 9); mc[2][1] = sx(int'(sw[4][8:0]), 9);
    mo[0] = sx(int'({sw[1][7:0], sw[0][31:27]}), 13);
    mo[1] = sx(int'({sw[3][7:0], sw[2][31:27]}), 13);
    mo[2] = sx(int'({sw[5][7:0], sw[4][31:27]}), 13);
    msc  = int'(sw[1][9:8]);
    msat = int'(sw[1][10]);
  endtask

  function automatic logic [23:0] ref_px(input logic [23:0] p);
    int x[3];
    int s, r, lo, hi;
    logic [23:0] o;
    x[0] = int'(p[23:16]); x[1] = int'(p[15:8]); x[2] = int'(p[7:0]);
    o = '0;
    for (int i = 0; i < 3; i++) begin
      s = 64 * mo[i];
      for (int j = 0; j < 3; j++) s += mc[i][j] * x[j];
      r  = fdiv(s * (1 << msc) + 256, 512);
      lo = msat ? 16 : 0;
      hi = msat ? ((i == 0) ? 235 : 240) : 255;
      if (r < lo) r = lo;
      if (r > hi) r = hi;
      o[(2 - i) * 8 +: 8] = 8'(r);
    end
    return o;
  endfunction

  // monitor: one time unit before each rising edge
  always @(negedge clk) begin
    #(HALF - 1);
    if (rst_ni) begin
      if (prev_stall) chk(out_valid_o && out_pix_o == prev_pix, "R10", out_pix_o, prev_pix);
      if (out_valid_o && !out_ready_i) chk(!in_ready_o, "R10", 24'(in_ready_o), 24'd0);
      prev_stall = out_valid_o && !out_ready_i;
      prev_pix   = out_pix_o;
      if (out_valid_o && out_ready_i) begin
        if (expq.size() == 0) chk(1'b0, tag, out_pix_o, 24'hxxxxxx);
        else begin
          chk(out_pix_o == expq[0], tag, out_pix_o, expq[0]);
          void'(expq.pop_front());
        end
      end
      mon_acc = in_valid_i && in_ready_o;
      if (mon_acc) expq.push_back(ref_px(in_pix_i));
      if (frame_start_i) begin
        if (preset_i == 2'd0) decode_shadow();
        else load_preset(int'(preset_i));
      end
      if (cfg_we_i && cfg_addr_i < 3'd6) sw[cfg_addr_i] = cfg_wdata_i;
    end
  end

  task automatic px(input logic [23:0] p, input bit fs = 0);
    @(negedge clk); #1;
    cfg_we_i = 0; in_valid_i = 1; in_pix_i = p; frame_start_i = fs;
  endtask

  task automatic idle(input int n = 6);
    @(negedge clk); #1;
    cfg_we_i = 0; in_valid_i = 0; frame_start_i = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_wr(input int a, input logic [31:0] d);
    @(negedge clk); #1;
    in_valid_i = 0; frame_start_i = 0;
    cfg_we_i = 1; cfg_addr_i = 3'(a); cfg_wdata_i = d;
  endtask

  task automatic commit(input int sel);
    @(negedge clk); #1;
    in_valid_i = 0; cfg_we_i = 0;
    preset_i = 2'(sel); frame_start_i = 1;
  endtask

  task automatic prog(input int scale, input int sat);
    logic [12:0] o[3];
    logic [8:0]  c[3][3];
    for (int i = 0; i < 3; i++) begin
      o[i] = 13'(po[i]);
      for (int j = 0; j < 3; j++) c[i][j] = 9'(pc[i][j]);
    end
    cfg_wr(0, {o[0][4:0], c[0][0], c[1][1], c[2][2]});
    cfg_wr(1, {21'd0, 1'(sat), 2'(scale), o[0][12:5]});
    cfg_wr(2, {o[1][4:0], c[0][1], c[1][0], c[2][0]});
    cfg_wr(3, {24'd0, o[1][12:5]});
    cfg_wr(4, {o[2][4:0], c[0][2], c[1][2], c[2][1]});
    cfg_wr(5, {24'd0, o[2][12:5]});
  endtask

  task automatic rnd_px(input int n);
    for (int k = 0; k < n; k++) px(24'($urandom));
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int first;
    rst_ni = 0; cfg_we_i = 0; cfg_addr_i = 0; cfg_wdata_i = 0; preset_i = 0;
    frame_start_i = 0; in_valid_i = 0; in_pix_i = 0; out_ready_i = 1;
    for (int w = 0; w < 6; w++) sw[w] = '0;
    load_preset(3);
    msat = 0;

    repeat (3) @(negedge clk);
    #(HALF - 1);
    chk(!out_valid_o, "R1", 24'(out_valid_o), 24'd0);
    @(negedge clk); #1 rst_ni = 1;
    #(HALF - 2);
    chk(in_ready_o && !out_valid_o, "R1", {22'd0, in_ready_o, out_valid_o}, 24'd2);

    // R11: pass-through after reset
    tag = "R11";
    px(24'h123456); px(24'hFF00A5); px(24'h000000); px(24'hFFFFFF); rnd_px(4);
    idle();

    // R9: latency probe
    tag = "R9";
    px(24'h405060);
    first = 0;
    for (int n = 1; n <= 5; n++) begin
      @(negedge clk); #1;
      in_valid_i = 0;
      #(HALF - 2);
      if (out_valid_o && first == 0) first = n;
    end
    chk(first == 3, "R9", 24'(first), 24'd3);
    idle();

    // R7: presets
    tag = "R7";
    commit(1);
    px(24'hFFFFFF); px(24'h000000); px(24'hFF0000); px(24'h00FF00); px(24'h0000FF); rnd_px(6);
    idle();
    commit(2);
    px(24'h108080); px(24'hEB8080); px(24'h000000); px(24'hFFFFFF); px(24'h80FF00); rnd_px(6);
    idle();
    commit(3);
    rnd_px(6);
    idle();

    // R2: column isolation with scale 3
    tag = "R2";
    for (int i = 0; i < 3; i++) begin
      po[i] = 0;
      for (int j = 0; j < 3; j++) pc[i][j] = 11 + 23 * (3 * i + j);
    end
    prog(3, 0);
    commit(0);
    px(24'h400000); px(24'h004000); px(24'h000040); rnd_px(4);
    idle();

    // R3: signed offsets with fractional bits
    tag = "R3";
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) pc[i][j] = (i == j) ? 100 : -7;
    po[0] = -1234; po[1] = 777; po[2] = -3;
    prog(2, 0);
    commit(0);
    px(24'h000000); px(24'hFFFFFF); px(24'h808080); rnd_px(6);
    idle();

    // R5: every scale setting
    tag = "R5";
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) pc[i][j] = 30 + 10 * i - 5 * j;
    po[0] = 40; po[1] = -40; po[2] = 5;
    for (int s = 0; s < 4; s++) begin
      prog(s, 0);
      commit(0);
      px(24'h102030); rnd_px(4);
      idle();
    end

    // R4: rounding halves and full-range clamps
    tag = "R4";
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) pc[i][j] = 0;
    pc[0][0] = 1; pc[1][1] = -1; pc[2][2] = 255; pc[2][0] = -256;
    po[0] = 0; po[1] = 512; po[2] = 0;
    prog(1, 0);
    commit(0);
    px(24'h800000); px(24'h7F0000); px(24'h008000); px(24'h0000FF); px(24'hFF00FF); px(24'hFF0000); rnd_px(4);
    idle();

    // R6: video-range clamp
    tag = "R6";
    pc[0][0] = 200; pc[0][1] = 100; pc[0][2] = 50;
    pc[1][0] = -200; pc[1][1] = 30;  pc[1][2] = 255;
    pc[2][0] = 255;  pc[2][1] = -90; pc[2][2] = -100;
    po[0] = -200; po[1] = 512; po[2] = 512;
    prog(1, 1);
    commit(0);
    px(24'h000000); px(24'hFFFFFF); px(24'hFF0000); px(24'h0000FF); rnd_px(6);
    idle();

    // R8: staged words do not act until a frame start; commit edge keeps old set
    tag = "R8";
    commit(3);
    idle(2);
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) pc[i][j] = (i == j) ? 64 : 0;
    po[0] = 400; po[1] = -400; po[2] = 0;
    prog(2, 0);
    preset_i = 2'd0;
    px(24'h112233); px(24'hA0B0C0);
    px(24'h445566, 1'b1);
    px(24'h445566); px(24'hF0F0F0);
    idle();
    preset_i = 2'd1;
    px(24'h0A0B0C); px(24'hC0C1C2);
    idle();

    // R10: random backpressure with frame starts mid-stream
    tag = "R10";
    for (int k = 0; k < 600; k++) begin
      @(negedge clk); #1;
      cfg_we_i = 0;
      out_ready_i = ($urandom_range(0, 2) != 0);
      frame_start_i = ($urandom_range(0, 19) == 0);
      if (frame_start_i) preset_i = 2'($urandom_range(0, 3));
      if (!in_valid_i || mon_acc) begin
        in_valid_i = ($urandom_range(0, 3) != 0);
        in_pix_i   = 24'($urandom);
      end
    end
    @(negedge clk); #1;
    in_valid_i = 0; frame_start_i = 0; out_ready_i = 1;
    repeat (10) @(negedge clk);

    tag = "R9";
    chk(expq.size() == 0, "R9", 24'(expq.size()), 24'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule